// File: doc/BRIEF.md
# Dual-Port Interrupt Status Register

This block holds the interrupt cause bits of a bridge between PCI and a local memory-mapped bus. Each cause bit is set by hardware and cleared by writing 1 to it. Three bits record datapath errors that arrive as event inputs: a failed PCI write, a failed PCI read, and discarded non-prefetchable read data. Three further bits come from edge detectors. Two of them watch the master-enable bit of the PCI command register, one for each direction of change. The third watches the active-low interrupt line for a falling edge.

The local bus can read and clear every bit at its status offset, and it can read and write a companion enable register. The PCI side can see the same status value and clear the three error bits. A single interrupt output is high while any status bit is set and also enabled. A set condition in a cycle takes priority over a clear in that same cycle, so no event is lost. The bridge configuration decides which bits exist. A bit that does not exist reads as 0.

All pins are plain control and status signals. Nothing streams through the block, so it has no valid/ready handshake. Register writes complete in one cycle and reads are combinational.

Top module: `irq_status_unit`

## Requirements
- R1: After a synchronous active-high reset, the status register reads 0, the enable register reads 0 and `irq` is low.
- R2: If `ev_wr_fail`, `ev_rd_fail` or `ev_np_discard` is high at a clock edge, status bit 0, 1 or 2 respectively is 1 after that edge. This is visible at local offset 0x3060 and on `pci_status`.
- R3: When `mst_en` changes from 1 to 0 between two clock edges, status bit 3 becomes 1. A change from 0 to 1 sets status bit 4. The previous sample of `mst_en` resets to 0.
- R4: A 1-to-0 change of `int_line_n` sets status bit 6. A 0-to-1 change sets nothing. The previous sample of `int_line_n` resets to 1.
- R5: A local write to offset 0x3060 clears every status bit whose data bit is 1. Data bits that are 0 leave their status bits unchanged. Writes to any other offset leave the status unchanged.
- R6: If the set condition of a bit occurs in the same cycle as a clear of that bit, the bit ends up 1. A clear of bit 4 during a falling edge of `mst_en` still takes effect, because only a rising edge sets bit 4. The same holds for bit 3 during a rising edge.
- R7: When `pci_clr_en` is high, each 1 in `pci_clr_mask[2:0]` clears the matching status bit. Mask bits 3 to 6 are ignored. If both ports clear the same bit in one cycle, the result is one ordinary clear.
- R8: Bit 5 is reserved and always reads 0. Bits 0, 1, 3 and 4 exist only in peripheral or host mode. Bit 6 exists only in host mode. Bit 2 exists only when `HAS_NP_PORT` is 1. An absent bit reads 0 in both the status and the enable register.
- R9: The enable register is read and written at local offset 0x3070. `irq` is high exactly while some status bit and its enable bit are both 1.
- R10: A read at offset 0x3060 returns the status value zero-extended to the data width. A read at an unmapped offset returns 0. `pci_status` always equals the status bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lb_wr_en | input | 1 | Local-bus write strobe |
| lb_wr_addr | input | ADDR_W | Local-bus write offset |
| lb_wr_data | input | DATA_W | Local-bus write data |
| lb_rd_addr | input | ADDR_W | Local-bus read offset |
| lb_rd_data | output | DATA_W | Local-bus read data, combinational |
| pci_clr_en | input | 1 | PCI-side write-1-to-clear strobe |
| pci_clr_mask | input | 7 | PCI-side clear bits (only 2:0 act) |
| pci_status | output | 7 | Status bits as seen from the PCI side |
| ev_wr_fail | input | 1 | PCI write failed |
| ev_rd_fail | input | 1 | PCI read failed |
| ev_np_discard | input | 1 | Non-prefetchable read data discarded |
| mst_en | input | 1 | PCI command register master-enable bit |
| int_line_n | input | 1 | Active-low interrupt line |
| irq | output | 1 | Masked interrupt request |

## Verification
The bench targets the cycles where a clear and a set meet. A design that let the clear win would lose the event and read 0 in those cycles. A design that treated any master-enable change as a qualifying transition would fail to clear bit 4 during a fall. It also drives both ports to clear in one cycle and sends PCI-side clears to bits 3 to 6. A decoder that ignored the mask width would wrongly drop bit 6. A second instance built in peripheral mode without the non-prefetchable port shows whether absent bits can still latch events or hold enable bits.

// File: rtl/irq_status_pkg.sv
package irq_status_pkg;

  localparam int STAT_W = 7;

  localparam int B_WR_FAIL    = 0;
  localparam int B_RD_FAIL    = 1;
  localparam int B_NP_DISCARD = 2;
  localparam int B_ME_FALL    = 3;
  localparam int B_ME_RISE    = 4;
  localparam int B_RSVD       = 5;
  localparam int B_INT_FALL   = 6;

  // bits the PCI-side window is allowed to clear
  localparam logic [STAT_W-1:0] PCI_CLR_BITS = 7'b000_0111;

  typedef enum logic [1:0] {
    BRIDGE_TARGET_ONLY = 2'd0,
    BRIDGE_PERIPH      = 2'd1,
    BRIDGE_HOST        = 2'd2
  } bridge_mode_e;

  function automatic logic [STAT_W-1:0] impl_mask(bridge_mode_e mode, bit has_np);
    logic [STAT_W-1:0] m;
    logic master_side;
    master_side = (mode == BRIDGE_PERIPH) || (mode == BRIDGE_HOST);
    m = '0;
    m[B_WR_FAIL]    = master_side;
    m[B_RD_FAIL]    = master_side;
    m[B_NP_DISCARD] = has_np;
    m[B_ME_FALL]    = master_side;
    m[B_ME_RISE]    = master_side;
    m[B_RSVD]       = 1'b0;
    m[B_INT_FALL]   = (mode == BRIDGE_HOST);
    return m;
  endfunction

endpackage

// File: rtl/irq_edge_detect.sv
module irq_edge_detect #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic sig_i,
  output logic rise_o,
  output logic fall_o
);

  logic prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= RST_VAL;
    else     prev_q <= sig_i;
  end

  // edges are reported in the cycle the new level is present, so the
  // owning status bit can see them together with a same-cycle clear
  always_comb begin
    rise_o = sig_i & ~prev_q;
    fall_o = ~sig_i & prev_q;
  end

endmodule

// File: rtl/irq_w1c_bit.sv
module irq_w1c_bit #(
  parameter logic IMPL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);

  logic q_q;
  logic q_d;

  always_comb begin
    if (IMPL) q_d = (q_q & ~clr_i) | set_i;   // set has priority
    else      q_d = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) q_q <= 1'b0;
    else     q_q <= q_d;
  end

  assign q_o = q_q;

endmodule

// File: rtl/irq_read_mux.sv
module irq_read_mux
  import irq_status_pkg::*;
#(
  parameter int                ADDR_W     = 16,
  parameter int                DATA_W     = 32,
  parameter logic [ADDR_W-1:0] STATUS_OFS = 16'h3060,
  parameter logic [ADDR_W-1:0] ENABLE_OFS = 16'h3070
) (
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [STAT_W-1:0] stat_i,
  input  logic [STAT_W-1:0] en_i,
  output logic [DATA_W-1:0] rd_data
);

  localparam int PAD_W = DATA_W - STAT_W;

  always_comb begin
    if (rd_addr == STATUS_OFS)      rd_data = {{PAD_W{1'b0}}, stat_i};
    else if (rd_addr == ENABLE_OFS) rd_data = {{PAD_W{1'b0}}, en_i};
    else                            rd_data = '0;
  end

endmodule

// File: rtl/irq_status_unit.sv
module irq_status_unit
  import irq_status_pkg::*;
#(
  parameter bridge_mode_e      MODE        = BRIDGE_HOST,
  parameter bit                HAS_NP_PORT = 1'b1,
  parameter int                ADDR_W      = 16,
  parameter int                DATA_W      = 32,
  parameter logic [ADDR_W-1:0] STATUS_OFS  = 16'h3060,
  parameter logic [ADDR_W-1:0] ENABLE_OFS  = 16'h3070
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lb_wr_en,
  input  logic [ADDR_W-1:0] lb_wr_addr,
  input  logic [DATA_W-1:0] lb_wr_data,
  input  logic [ADDR_W-1:0] lb_rd_addr,
  output logic [DATA_W-1:0] lb_rd_data,
  input  logic              pci_clr_en,
  input  logic [STAT_W-1:0] pci_clr_mask,
  output logic [STAT_W-1:0] pci_status,
  input  logic              ev_wr_fail,
  input  logic              ev_rd_fail,
  input  logic              ev_np_discard,
  input  logic              mst_en,
  input  logic              int_line_n,
  output logic              irq
);

  localparam logic [STAT_W-1:0] IMPL = impl_mask(MODE, HAS_NP_PORT);

  logic me_rise, me_fall;
  logic il_rise, il_fall;
  logic [STAT_W-1:0] set_vec;
  logic [STAT_W-1:0] clr_vec;
  logic [STAT_W-1:0] stat_q;
  logic [STAT_W-1:0] en_q;
  logic              hit_stat, hit_en;
  logic              unused_ok;

  irq_edge_detect #(.RST_VAL(1'b0)) u_me_edge (
    .clk(clk), .rst(rst), .sig_i(mst_en), .rise_o(me_rise), .fall_o(me_fall)
  );

  irq_edge_detect #(.RST_VAL(1'b1)) u_il_edge (
    .clk(clk), .rst(rst), .sig_i(int_line_n), .rise_o(il_rise), .fall_o(il_fall)
  );

  always_comb begin
    set_vec               = '0;
    set_vec[B_WR_FAIL]    = ev_wr_fail;
    set_vec[B_RD_FAIL]    = ev_rd_fail;
    set_vec[B_NP_DISCARD] = ev_np_discard;
    set_vec[B_ME_FALL]    = me_fall;
    set_vec[B_ME_RISE]    = me_rise;
    set_vec[B_INT_FALL]   = il_fall;
  end

  assign hit_stat = lb_wr_en && (lb_wr_addr == STATUS_OFS);
  assign hit_en   = lb_wr_en && (lb_wr_addr == ENABLE_OFS);

  // both ports merge into one clear vector, so a double clear is a single clear
  always_comb begin
    clr_vec = '0;
    if (hit_stat)   clr_vec = clr_vec | lb_wr_data[STAT_W-1:0];
    if (pci_clr_en) clr_vec = clr_vec | (pci_clr_mask & PCI_CLR_BITS);
  end

  for (genvar i = 0; i < STAT_W; i++) begin : g_bit
    irq_w1c_bit #(.IMPL(IMPL[i])) u_bit (
      .clk(clk), .rst(rst), .set_i(set_vec[i]), .clr_i(clr_vec[i]), .q_o(stat_q[i])
    );
  end

  always_ff @(posedge clk) begin
    if (rst)         en_q <= '0;
    else if (hit_en) en_q <= lb_wr_data[STAT_W-1:0] & IMPL;
  end

  irq_read_mux #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .STATUS_OFS(STATUS_OFS), .ENABLE_OFS(ENABLE_OFS)
  ) u_rd (
    .rd_addr(lb_rd_addr), .stat_i(stat_q), .en_i(en_q), .rd_data(lb_rd_data)
  );

  assign pci_status = stat_q;
  assign irq        = |(stat_q & en_q);

  assign unused_ok = il_rise ^ (^lb_wr_data) ^ (^pci_clr_mask);

endmodule

// File: rtl/irq_status_chk.sv
module irq_status_chk
  import irq_status_pkg::*;
#(
  parameter bridge_mode_e      MODE        = BRIDGE_HOST,
  parameter bit                HAS_NP_PORT = 1'b1,
  parameter int                ADDR_W      = 16,
  parameter int                DATA_W      = 32,
  parameter logic [ADDR_W-1:0] STATUS_OFS  = 16'h3060
) (
  input logic              clk,
  input logic              rst,
  input logic              lb_wr_en,
  input logic [ADDR_W-1:0] lb_wr_addr,
  input logic [DATA_W-1:0] lb_wr_data,
  input logic [ADDR_W-1:0] lb_rd_addr,
  input logic [DATA_W-1:0] lb_rd_data,
  input logic              pci_clr_en,
  input logic [STAT_W-1:0] pci_clr_mask,
  input logic [STAT_W-1:0] pci_status,
  input logic              ev_wr_fail,
  input logic              mst_en,
  input logic              int_line_n,
  input logic              irq
);

  localparam logic [STAT_W-1:0] IMPL = impl_mask(MODE, HAS_NP_PORT);

  // R6
  ev_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (IMPL[B_WR_FAIL] && ev_wr_fail) |=> pci_status[B_WR_FAIL]);

  // R3
  me_rise_chk: assert property (@(posedge clk) disable iff (rst)
    (IMPL[B_ME_RISE] && $rose(mst_en)) |=> pci_status[B_ME_RISE]);

  // R4
  int_fall_chk: assert property (@(posedge clk) disable iff (rst)
    (IMPL[B_INT_FALL] && $fell(int_line_n)) |=> pci_status[B_INT_FALL]);

  // R5
  lb_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (lb_wr_en && lb_wr_addr == STATUS_OFS && lb_wr_data[B_WR_FAIL] && !ev_wr_fail)
    |=> !pci_status[B_WR_FAIL]);

  // R7
  pci_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (pci_clr_en && pci_clr_mask[B_WR_FAIL] && !ev_wr_fail) |=> !pci_status[B_WR_FAIL]);

  // R8
  absent_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (pci_status & ~IMPL) == '0);

  // R9
  quiet_irq_chk: assert property (@(posedge clk) disable iff (rst)
    (pci_status == '0) |-> !irq);

  // R10
  view_match_chk: assert property (@(posedge clk) disable iff (rst)
    (lb_rd_addr == STATUS_OFS) |-> (lb_rd_data == DATA_W'(pci_status)));

endmodule

bind irq_status_unit irq_status_chk #(
  .MODE(MODE), .HAS_NP_PORT(HAS_NP_PORT), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
  .STATUS_OFS(STATUS_OFS)
) u_chk (
  .clk(clk), .rst(rst), .lb_wr_en(lb_wr_en), .lb_wr_addr(lb_wr_addr),
  .lb_wr_data(lb_wr_data), .lb_rd_addr(lb_rd_addr), .lb_rd_data(lb_rd_data),
  .pci_clr_en(pci_clr_en), .pci_clr_mask(pci_clr_mask), .pci_status(pci_status),
  .ev_wr_fail(ev_wr_fail), .mst_en(mst_en), .int_line_n(int_line_n), .irq(irq)
);

// File: tb/test_irq_status_unit.sv
module test_irq_status_unit;
  import irq_status_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam logic [15:0] A_STAT = 16'h3060;
  localparam logic [15:0] A_EN   = 16'h3070;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        lb_wr_en = 1'b0;
  logic [15:0] lb_wr_addr = '0;
  logic [31:0] lb_wr_data = '0;
  logic [15:0] lb_rd_addr = A_STAT;
  logic [31:0] lb_rd_data, lb_rd_data_m;
  logic        pci_clr_en = 1'b0;
  logic [6:0]  pci_clr_mask = '0;
  logic [6:0]  pci_status, pci_status_m;
  logic        ev_wr_fail = 1'b0, ev_rd_fail = 1'b0, ev_np_discard = 1'b0;
  logic        mst_en = 1'b0, int_line_n = 1'b1;
  logic        irq, irq_m;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_status_unit i_irq_status_unit (
    .clk(clk), .rst(rst), .lb_wr_en(lb_wr_en), .lb_wr_addr(lb_wr_addr),
    .lb_wr_data(lb_wr_data), .lb_rd_addr(lb_rd_addr), .lb_rd_data(lb_rd_data),
    .pci_clr_en(pci_clr_en), .pci_clr_mask(pci_clr_mask), .pci_status(pci_status),
    .ev_wr_fail(ev_wr_fail), .ev_rd_fail(ev_rd_fail), .ev_np_discard(ev_np_discard),
    .mst_en(mst_en), .int_line_n(int_line_n), .irq(irq)
  );

  // peripheral mode, no non-prefetchable port: bits 0,1,3,4 only
  irq_status_unit #(.MODE(BRIDGE_PERIPH), .HAS_NP_PORT(1'b0)) i_irq_status_unit_min (
    .clk(clk), .rst(rst), .lb_wr_en(lb_wr_en), .lb_wr_addr(lb_wr_addr),
    .lb_wr_data(lb_wr_data), .lb_rd_addr(lb_rd_addr), .lb_rd_data(lb_rd_data_m),
    .pci_clr_en(pci_clr_en), .pci_clr_mask(pci_clr_mask), .pci_status(pci_status_m),
    .ev_wr_fail(ev_wr_fail), .ev_rd_fail(ev_rd_fail), .ev_np_discard(ev_np_discard),
    .mst_en(mst_en), .int_line_n(int_line_n), .irq(irq_m)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic rd(input logic [15:0] a, output logic [31:0] d);
    lb_rd_addr = a;
    #1;
    d = lb_rd_data;
  endtask

  task automatic wr(input logic [15:0] a, input logic [31:0] d);
    lb_wr_en = 1'b1; lb_wr_addr = a; lb_wr_data = d;
    cyc();
    lb_wr_en = 1'b0; lb_wr_data = '0;
  endtask

  task automatic stat_is(input string req, input logic [6:0] exp);
    logic [31:0] d;
    rd(A_STAT, d);
    chk(req, d, {25'd0, exp});
    chk({req, " pci view"}, {25'd0, pci_status}, {25'd0, exp});
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(A_STAT, d); chk("R1 status after reset", d, 32'h0);
    rd(A_EN, d);   chk("R1 enable after reset", d, 32'h0);
    chk("R1 irq after reset", {31'd0, irq}, 32'h0);
  endtask

  task automatic t_events();
    ev_wr_fail = 1'b1; cyc(); ev_wr_fail = 1'b0;
    stat_is("R2 write failure bit0", 7'h01);
    ev_rd_fail = 1'b1; cyc(); ev_rd_fail = 1'b0;
    stat_is("R2 read failure bit1", 7'h03);
    ev_np_discard = 1'b1; cyc(); ev_np_discard = 1'b0;
    stat_is("R2 discard bit2 / R10", 7'h07);
  endtask

  task automatic t_w1c();
    logic [31:0] d;
    wr(A_STAT, 32'h0);  stat_is("R5 zero write no effect", 7'h07);
    wr(16'h3064, 32'h7F); stat_is("R5 other offset no effect", 7'h07);
    rd(16'h3064, d); chk("R10 unmapped read zero", d, 32'h0);
    wr(A_STAT, 32'h02); stat_is("R5 clear bit1 only", 7'h05);
    wr(A_STAT, 32'h05); stat_is("R5 clear rest", 7'h00);
  endtask

  task automatic t_master();
    mst_en = 1'b1; cyc(); stat_is("R3 rise sets bit4", 7'h10);
    cyc();              stat_is("R3 steady high no new bit", 7'h10);
    mst_en = 1'b0; cyc(); stat_is("R3 fall sets bit3", 7'h18);
    wr(A_STAT, 32'h18); stat_is("R5 clear master bits", 7'h00);
  endtask

  task automatic t_intline();
    int_line_n = 1'b0; cyc(); stat_is("R4 fall sets bit6", 7'h40);
    wr(A_STAT, 32'h40); stat_is("R4 cleared", 7'h00);
    int_line_n = 1'b1; cyc(); stat_is("R4 rise sets nothing", 7'h00);
  endtask

  task automatic t_set_wins();
    ev_wr_fail = 1'b1; wr(A_STAT, 32'h01); ev_wr_fail = 1'b0;
    stat_is("R6 event beats clear", 7'h01);
    wr(A_STAT, 32'h01); stat_is("R6 clear alone works", 7'h00);
    mst_en = 1'b1; cyc(); stat_is("R6 setup rise", 7'h10);
    mst_en = 1'b0; wr(A_STAT, 32'h10);
    stat_is("R6 fall clears bit4 and sets bit3", 7'h08);
    mst_en = 1'b1; wr(A_STAT, 32'h08);
    stat_is("R6 rise clears bit3 and sets bit4", 7'h10);
    wr(A_STAT, 32'h10); stat_is("R6 cleanup", 7'h00);
  endtask

  task automatic t_pci_clear();
    ev_wr_fail = 1'b1; ev_rd_fail = 1'b1; ev_np_discard = 1'b1; int_line_n = 1'b0;
    cyc();
    ev_wr_fail = 1'b0; ev_rd_fail = 1'b0; ev_np_discard = 1'b0;
    stat_is("R7 setup", 7'h47);
    pci_clr_en = 1'b1; pci_clr_mask = 7'h7F; cyc(); pci_clr_en = 1'b0;
    stat_is("R7 pci clears only bits 2:0", 7'h40);
    ev_wr_fail = 1'b1; ev_rd_fail = 1'b1; cyc(); ev_wr_fail = 1'b0; ev_rd_fail = 1'b0;
    stat_is("R7 setup two bits", 7'h43);
    pci_clr_en = 1'b1; pci_clr_mask = 7'h02; wr(A_STAT, 32'h01); pci_clr_en = 1'b0;
    stat_is("R7 both ports different bits", 7'h40);
    ev_wr_fail = 1'b1; cyc(); ev_wr_fail = 1'b0;
    pci_clr_en = 1'b1; pci_clr_mask = 7'h01; wr(A_STAT, 32'h01); pci_clr_en = 1'b0;
    stat_is("R7 both ports same bit", 7'h40);
    wr(A_STAT, 32'h40); stat_is("R7 cleanup", 7'h00);
  endtask

  task automatic t_reserved();
    logic [31:0] d;
    wr(A_EN, 32'hFFFF_FFFF);
    rd(A_EN, d);
    chk("R9 enable readback implemented bits", d, 32'h5F);
    chk("R8 min-config enable readback", lb_rd_data_m, 32'h1B);
    wr(A_EN, 32'h0);
    int_line_n = 1'b1; cyc();
    ev_wr_fail = 1'b1; ev_np_discard = 1'b1; int_line_n = 1'b0;
    cyc();
    ev_wr_fail = 1'b0; ev_np_discard = 1'b0;
    stat_is("R8 host config bits", 7'h45);
    chk("R8 min config drops absent bits", {25'd0, pci_status_m}, 32'h01);
    wr(A_STAT, 32'h7F); stat_is("R8 cleanup, bit5 stays 0", 7'h00);
  endtask

  task automatic t_irq();
    ev_rd_fail = 1'b1; cyc(); ev_rd_fail = 1'b0;
    chk("R9 irq low when not enabled", {31'd0, irq}, 32'h0);
    wr(A_EN, 32'h02);
    chk("R9 irq high when enabled", {31'd0, irq}, 32'h1);
    wr(A_EN, 32'h01);
    chk("R9 irq low on other enable", {31'd0, irq}, 32'h0);
    wr(A_EN, 32'h02);
    wr(A_STAT, 32'h02);
    chk("R9 irq low after clear", {31'd0, irq}, 32'h0);
  endtask

  initial begin
    repeat (3) cyc();
    t_reset();
    rst = 1'b0;
    cyc();
    t_reset();
    t_events();
    t_w1c();
    t_master();
    t_intline();
    t_set_wins();
    t_pci_clear();
    t_reserved();
    t_irq();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule